// File: doc/BRIEF.md
# Bus-Attached SPI Master with Handshake-Cleared Status

This block connects an 8-bit processor bus to a serial peripheral link. Software writes a control byte to choose clock idle level, clock phase, a rate divider, interrupt enable and master operation. A write to the data address then shifts one byte out on MOSI, most significant bit first, and shifts one byte in from MISO on a clock derived from the system clock.

When the byte is done, a completion flag sets in the status register and the received byte becomes readable at the data address. If interrupts are enabled, an interrupt line asserts. The completion flag, and the collision flag raised by a data write during a transfer, are released only by a two-step handshake: a status read that sees a flag set, followed by a read or write of the data address. Until that status read has happened, data writes are refused.

A low level on the slave-select input while the block is master records a mode fault. It leaves master operation and abandons any transfer in flight.

Top module: `sbus_spi`

## Requirements
- R1: After reset, the control, status and data registers all read 0, sck_o and irq_o are low, and mosi_o is low.
- R2: Outside a transfer, sck_o rests at the polarity bit (control bit 3): low when 0, high when 1.
- R3: Control bits [1:0] select the SCK period in system clocks: 00 gives 2, 01 gives 4, 10 gives 16, 11 gives 32. The status completion bit sets 8 periods after the clock edge that accepts the data write, after exactly 16 SCK edges.
- R4: Bytes travel MSB first. With the phase bit (control bit 2) at 0, MOSI carries the MSB before the first edge, data is sampled on leading edges and changes on trailing edges. With it at 1, data changes on leading edges and is sampled on trailing edges.
- R5: At the end of a byte, status bit 7 (completion) sets and a read of address 2 returns the byte received from MISO.
- R6: Status bits 7 and 6 clear only after a read of address 1 that sees either of them set, followed by a read or write of address 2. A data access without that prior status read leaves them set.
- R7: While status bit 7 is set and no arming status read has occurred, a write to address 2 is ignored and starts no transfer.
- R8: A permitted write to address 2 during a transfer sets status bit 6 (collision). The transfer in progress is unaffected and still sends the original byte.
- R9: Writes to address 1 have no effect on the status register.
- R10: irq_o is high exactly while status bit 7 and the interrupt-enable bit (control bit 5) are both set.
- R11: With the master bit (control bit 4) at 0, a data write starts no transfer and SCK stays idle whatever the rate bits hold.
- R12: ss_ni low while the master bit is set sets status bit 4 and clears the master bit. Bit 4 clears only by a status read that sees it set, followed by a write to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe (side effects of reading) |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_ni | input | 1 | Slave select, active low; low in master mode is a fault |

## Verification
A stuck or misarmed handshake state shows on the next status peek. The flag either survives a legal clear or vanishes after an illegal one, and an inhibited write shows within one transfer period as SCK edges that should not exist. A divider or edge-count error moves the completion flag away from the cycle of 8 SCK periods counted by the bench. A phase or shift-order error corrupts the byte captured by the bench-side slave or the byte read back at the data address as soon as the transfer ends.

// File: rtl/sbus_spi_pkg.sv
package sbus_spi_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  localparam int ST_DONE = 7;
  localparam int ST_WCOL = 6;
  localparam int ST_MODF = 4;

  typedef struct packed {
    logic       ie;
    logic       mstr;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/sbus_spi_clkgen.sv
module sbus_spi_clkgen #(
  parameter int CNT_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  // half period in system clocks, minus one
  always_comb begin
    unique case (rate_i)
      2'd0:    half_m1 = CNT_W'(0);
      2'd1:    half_m1 = CNT_W'(1);
      2'd2:    half_m1 = CNT_W'(7);
      default: half_m1 = CNT_W'(15);
    endcase
  end

  assign tick_o = run_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sbus_spi_shift.sv
module sbus_spi_shift #(
  parameter  int DW = 8,
  localparam int EW = $clog2(2*DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [DW-1:0] tx_i,
  input  logic          tick_i,
  input  logic          cpha_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o,
  output logic          mosi_o,
  output logic          phase_o
);
  localparam logic [EW-1:0] LAST = EW'(2*DW-1);

  logic [DW-1:0] tx_q, rx_q, rx_nxt;
  logic [EW-1:0] edge_q;
  logic          busy_q, phase_q;
  logic          lead, last, smp, shf, step;

  assign lead = ~edge_q[0];
  assign last = (edge_q == LAST);
  assign step = busy_q & tick_i;
  assign smp  = step & (cpha_i ? ~lead : lead);
  assign shf  = step & (cpha_i ? (lead & (edge_q != '0)) : (~lead & ~last));

  assign rx_nxt  = smp ? {rx_q[DW-2:0], miso_i} : rx_q;
  assign done_o  = step & last & ~abort_i;
  assign rx_o    = rx_nxt;
  assign busy_o  = busy_q;
  assign mosi_o  = tx_q[DW-1];
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= '0;
      rx_q    <= '0;
      edge_q  <= '0;
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      edge_q  <= '0;
    end else if (start_i && !busy_q) begin
      tx_q    <= tx_i;
      rx_q    <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      busy_q  <= 1'b1;
    end else if (step) begin
      phase_q <= ~phase_q;
      edge_q  <= edge_q + 1'b1;
      rx_q    <= rx_nxt;
      if (shf)  tx_q   <= {tx_q[DW-2:0], 1'b0};
      if (last) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sbus_spi.sv
module sbus_spi
  import sbus_spi_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              ss_ni
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic              spif_q, wcol_q, modf_q, arm_q, modf_arm_q;
  logic [DATA_W-1:0] rbuf_q, rx_w;
  logic              busy, done, tick, phase;

  logic st_rd, dat_acc, dat_wr, ctl_wr;
  logic inhibit, wr_ok, start, collide, clr, modf_evt;

  assign st_rd   = rd_en_i && (addr_i == A_STAT);
  assign dat_acc = (rd_en_i || wr_en_i) && (addr_i == A_DATA);
  assign dat_wr  = wr_en_i && (addr_i == A_DATA);
  assign ctl_wr  = wr_en_i && (addr_i == A_CTRL);

  assign modf_evt = ctrl_q.mstr && !ss_ni;
  assign inhibit  = spif_q && !arm_q;
  assign wr_ok    = dat_wr && !inhibit;
  assign start    = wr_ok && !busy && ctrl_q.mstr && !modf_evt;
  assign collide  = wr_ok && busy;
  assign clr      = dat_acc && arm_q;

  sbus_spi_clkgen #(.CNT_W(CNT_W)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .rate_i (ctrl_q.rate),
    .tick_o (tick)
  );

  sbus_spi_shift #(.DW(DATA_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (modf_evt),
    .tx_i    (wdata_i),
    .tick_i  (tick),
    .cpha_i  (ctrl_q.cpha),
    .miso_i  (miso_i),
    .busy_o  (busy),
    .done_o  (done),
    .rx_o    (rx_w),
    .mosi_o  (mosi_o),
    .phase_o (phase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      spif_q     <= 1'b0;
      wcol_q     <= 1'b0;
      modf_q     <= 1'b0;
      arm_q      <= 1'b0;
      modf_arm_q <= 1'b0;
      rbuf_q     <= '0;
    end else begin
      if (ctl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (modf_evt) ctrl_q.mstr <= 1'b0;

      if (done) begin
        spif_q <= 1'b1;
        rbuf_q <= rx_w;
      end else if (clr) begin
        spif_q <= 1'b0;
      end

      if (collide)  wcol_q <= 1'b1;
      else if (clr) wcol_q <= 1'b0;

      if (st_rd && (spif_q || wcol_q)) arm_q <= 1'b1;
      else if (dat_acc)                arm_q <= 1'b0;

      // mode fault: status read arms, control write releases
      if (modf_evt) begin
        modf_q <= 1'b1;
      end else if (ctl_wr && modf_arm_q) begin
        modf_q     <= 1'b0;
        modf_arm_q <= 1'b0;
      end else if (st_rd && modf_q) begin
        modf_arm_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = DATA_W'(ctrl_q);
      A_STAT: begin
        rdata_o[ST_DONE] = spif_q;
        rdata_o[ST_WCOL] = wcol_q;
        rdata_o[ST_MODF] = modf_q;
      end
      A_DATA: rdata_o = rbuf_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = spif_q && ctrl_q.ie;
  assign sck_o = ctrl_q.cpol ^ (busy && phase);
endmodule

// File: rtl/sbus_spi_chk.sv
module sbus_spi_chk #(
  parameter  int DW = 8,
  localparam int EW = $clog2(2*DW) + 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic       busy_i,
  input logic       tick_i,
  input logic       spif_i,
  input logic       wcol_i,
  input logic       arm_i,
  input logic       cpol_i,
  input logic       sck_i
);
  localparam logic [EW-1:0] LAST = EW'(2*DW-1);

  logic [EW-1:0] tcnt;
  logic          dat_acc, dat_wr;

  assign dat_acc = (rd_en_i || wr_en_i) && (addr_i == 2'd2);
  assign dat_wr  = wr_en_i && (addr_i == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tcnt <= '0;
    else if (!busy_i) tcnt <= '0;
    else if (tick_i)  tcnt <= tcnt + 1'b1;
  end

  a_r2_sck_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sck_i == cpol_i);

  a_r3_edge_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && tick_i && tcnt == LAST) |=> !busy_i);

  a_r3_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> tcnt <= LAST);

  a_r5_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spif_i) |-> $past(busy_i));

  a_r6_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spif_i) |-> $past(arm_i && dat_acc));

  a_r7_inhibit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && spif_i && !arm_i) |=> !$rose(busy_i));

  a_r8_wcol_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wcol_i) |-> $past(busy_i));
endmodule

bind sbus_spi sbus_spi_chk #(.DW(sbus_spi_pkg::DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .busy_i  (busy),
  .tick_i  (tick),
  .spif_i  (spif_q),
  .wcol_i  (wcol_q),
  .arm_i   (arm_q),
  .cpol_i  (ctrl_q.cpol),
  .sck_i   (sck_o)
);

// File: tb/test_sbus_spi.sv
module test_sbus_spi;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;
  logic       ss_n = 1'b1;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  sbus_spi i_sbus_spi (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .ss_ni(ss_n)
  );

  typedef struct packed {
    logic [7:0] ctrl;
    logic [7:0] mtx;
    logic [7:0] stx;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h10, 8'hA5, 8'h3C},
    '{8'h15, 8'h5A, 8'hC3},
    '{8'h1A, 8'h81, 8'h7E},
    '{8'h3F, 8'h01, 8'h80},
    '{8'h3C, 8'hFF, 8'h00},
    '{8'h19, 8'h00, 8'hFF},
    '{8'h16, 8'h96, 8'h69},
    '{8'h13, 8'h3C, 8'hA5}
  };

  // bench-side slave
  logic       s_en = 1'b0, s_cpha = 1'b0;
  logic [7:0] s_tx = '0, s_rx = '0;
  int         s_ecnt = 0;

  always @(sck) begin
    if (s_en) begin
      if (!s_cpha) begin
        if (s_ecnt % 2 == 0) s_rx = {s_rx[6:0], mosi};
        else if (s_ecnt < 15) miso = s_tx[7 - (s_ecnt + 1) / 2];
      end else begin
        if (s_ecnt % 2 == 0) miso = s_tx[7 - s_ecnt / 2];
        else s_rx = {s_rx[6:0], mosi};
      end
      s_ecnt++;
    end
  end

  task automatic slave_load(input logic [7:0] tx, input logic cpha);
    s_tx = tx; s_cpha = cpha; s_rx = '0; s_ecnt = 0;
    miso = cpha ? 1'b0 : tx[7];
    s_en = 1'b1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_done(output int n);
    logic [7:0] st;
    n = 0;
    peek(2'd1, st);
    while (!st[7] && n < 2000) begin
      @(negedge clk); n++;
      peek(2'd1, st);
    end
  endtask

  function automatic int div_of(input logic [1:0] r);
    case (r)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 16;
      default: return 32;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, d); check("R1 ctrl", d, 8'h00);
    peek(2'd1, d); check("R1 status", d, 8'h00);
    peek(2'd2, d); check("R1 data", d, 8'h00);
    check("R1 sck/irq/mosi", {sck, irq, mosi}, 3'b000);

    // vector walk: R2 R3 R4 R5 R6 R10
    foreach (VECS[i]) begin
      bus_wr(2'd0, VECS[i].ctrl);
      check("R2 idle before", sck, VECS[i].ctrl[3]);
      slave_load(VECS[i].stx, VECS[i].ctrl[2]);
      bus_wr(2'd2, VECS[i].mtx);
      wait_done(n);
      check("R3 cycles to done", n, 8 * div_of(VECS[i].ctrl[1:0]));
      check("R3 sck edges", s_ecnt, 16);
      check("R2 idle after", sck, VECS[i].ctrl[3]);
      check("R4 mosi byte", s_rx, VECS[i].mtx);
      check("R10 irq", irq, VECS[i].ctrl[5]);
      s_en = 1'b0;
      bus_rd(2'd1, d); check("R5 status done", d, 8'h80);
      bus_rd(2'd2, d); check("R5 rx byte", d, VECS[i].stx);
      peek(2'd1, d); check("R6 cleared", d, 8'h00);
      check("R10 irq low", irq, 1'b0);
    end

    // R9 R7 R6: writes to status, inhibited data write, unarmed data read
    bus_wr(2'd0, 8'h10);
    slave_load(8'h4D, 1'b0);
    bus_wr(2'd2, 8'h11);
    wait_done(n);
    s_en = 1'b0;
    bus_wr(2'd1, 8'hFF);
    peek(2'd1, d); check("R9 status write ignored", d, 8'h80);
    bus_wr(2'd1, 8'h00);
    peek(2'd1, d); check("R9 status write zero ignored", d, 8'h80);
    slave_load(8'h00, 1'b0);
    bus_wr(2'd2, 8'h22);
    repeat (40) @(negedge clk);
    check("R7 no edges", s_ecnt, 0);
    s_en = 1'b0;
    peek(2'd1, d); check("R7 flag kept", d, 8'h80);
    bus_rd(2'd2, d); check("R6 unarmed read data", d, 8'h4D);
    peek(2'd1, d); check("R6 unarmed read keeps flag", d, 8'h80);
    bus_rd(2'd1, d);
    bus_rd(2'd2, d);
    peek(2'd1, d); check("R6 armed clear", d, 8'h00);

    // R8 collision
    bus_wr(2'd0, 8'h13);
    slave_load(8'h5C, 1'b0);
    bus_wr(2'd2, 8'hC3);
    repeat (20) @(negedge clk);
    bus_wr(2'd2, 8'h00);
    peek(2'd1, d); check("R8 wcol set", d, 8'h40);
    wait_done(n);
    s_en = 1'b0;
    peek(2'd1, d); check("R8 status both", d, 8'hC0);
    check("R8 original byte sent", s_rx, 8'hC3);
    bus_rd(2'd1, d);
    bus_rd(2'd2, d); check("R8 rx intact", d, 8'h5C);
    peek(2'd1, d); check("R6 both cleared", d, 8'h00);

    // R11 slave mode
    bus_wr(2'd0, 8'h03);
    slave_load(8'h00, 1'b0);
    bus_wr(2'd2, 8'h77);
    repeat (600) @(negedge clk);
    check("R11 no edges", s_ecnt, 0);
    s_en = 1'b0;
    peek(2'd1, d); check("R11 no done", d, 8'h00);
    check("R11 sck idle", sck, 1'b0);

    // R12 mode fault
    bus_wr(2'd0, 8'h10);
    @(negedge clk); ss_n = 1'b0;
    @(negedge clk); ss_n = 1'b1;
    peek(2'd1, d); check("R12 modf set", d, 8'h10);
    peek(2'd0, d); check("R12 master cleared", d, 8'h00);
    bus_wr(2'd0, 8'h10);
    peek(2'd1, d); check("R12 unarmed ctrl write keeps", d, 8'h10);
    bus_rd(2'd1, d);
    bus_wr(2'd0, 8'h10);
    peek(2'd1, d); check("R12 cleared", d, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule